// File: doc/BRIEF.md
# Instruction-Driven Transform Sequencer

This block is the control unit of a transform engine that sits next to memory. A host programs it with ordinary memory writes. Each instruction written to one fixed address is appended to a two-entry instruction buffer. Writing the start code to a status address starts a run. The sequencer then takes the buffered instructions in the order they were written. For each one it decodes the direction (forward or inverse transform), a reference-multiply flag and the transform length, given as log2 of the point count.

For every valid instruction the block runs one stage per power of two of the length. It holds a stage request until an external address generator and arithmetic unit acknowledge that stage. While a stage is requested, the block drives per-stage mode controls. These are the direction, a multiply enable for the matched-filter product, and a real/imaginary swap applied to the results of the final inverse stage. A forward transform with the flag set multiplies during its last stage. An inverse transform with the flag set multiplies during its first stage. When no instruction remains, the status moves to an end code, which the host polls. The host clears the block with a write of zero.

Instruction writes are broadcast and are taken whatever rank they target. Status writes act only on the rank that matches the block's own rank parameter.

Top module: `xform_sequencer`

## Requirements
- R1: After reset, stat_code is 0 (idle), stat_err is 0, instr_count is 0 and stage_req is low.
- R2: An instruction word holds the direction in bit 0 (0 forward, 1 inverse), the multiply flag in bit 1, and log2 of the length in bits 6:2. A valid instruction yields exactly log2N stage requests with xf_stage counting 0 up to log2N-1 and xf_log2n equal to the field. Each request is held, with a stable stage index, until stage_done is seen.
- R3: A write of the instruction address while not busy appends the word. At most two are stored; further instruction writes are dropped, and instr_count reports the number stored.
- R4: Instruction writes are accepted for any wr_rank value. Status writes take effect only when wr_rank equals the MY_RANK parameter.
- R5: No stage is requested until the start code 1 is written to the status address; stat_code is 1 for the whole run.
- R6: Instructions run in the order written. After the last one, stat_code becomes 2 (end) and no further stage is requested.
- R7: xf_inv follows bit 0 of the running instruction. xf_mul is high only for flagged instructions: on the last stage of a forward transform, or on the first stage of an inverse one.
- R8: xf_swap is high only on the last stage of an inverse transform.
- R9: An instruction whose log2 field is 0 or above 16, or whose bits 31:7 are not all zero, runs no stage. It sets stat_err, and the following instruction still runs.
- R10: While stat_code is 1, instruction writes and status writes have no effect.
- R11: A status write of 0 while not busy returns stat_code to 0 and clears stat_err and instr_count. A new start clears stat_err.
- R12: A start with an empty buffer moves stat_code straight to 2 without any stage request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW | Write address (instruction or status) |
| wr_rank | input | RW | Rank targeted by the write |
| wr_data | input | 32 | Write data |
| stat_code | output | 2 | Status: 0 idle, 1 busy, 2 end |
| stat_err | output | 1 | Malformed instruction seen in this run |
| instr_count | output | CW | Number of buffered instructions |
| stage_req | output | 1 | Stage request to the datapath |
| stage_done | input | 1 | Datapath acknowledge of the requested stage |
| xf_log2n | output | 5 | log2 of the running transform length |
| xf_stage | output | 5 | Index of the requested stage |
| xf_inv | output | 1 | Inverse transform selected |
| xf_mul | output | 1 | Reference multiply in this stage |
| xf_swap | output | 1 | Real/imaginary swap on this stage's output |

## Verification
The bench sweeps every length field from 0 to 17 under all four direction/multiply combinations. It acknowledges stages with varying delay, so a design that counted one stage too many or too few, or let the index move before the acknowledge, shows a mismatch. A design that placed the multiply on the wrong end of the stage loop would flag the first stage of a forward transform, or the last stage of an inverse one. Malformed words placed first in a pair catch a sequencer that stalls or ends early after an abort. Writes during a run, a third instruction, a wrong-rank start and an empty start catch buffers that overwrite live instructions, count past two or start when they should not.

// File: rtl/xform_sequencer.sv
module xform_sequencer #(
  parameter int AW          = 4,
  parameter int RW          = 1,
  parameter int MY_RANK     = 0,
  parameter int INSTR_ADDR  = 0,
  parameter int STATUS_ADDR = 1,
  parameter int SLOTS       = 2,
  parameter int MAX_LOG2    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [RW-1:0] wr_rank,
  input  logic [31:0]   wr_data,
  output logic [1:0]    stat_code,
  output logic          stat_err,
  output logic [$clog2(SLOTS+1)-1:0] instr_count,
  output logic          stage_req,
  input  logic          stage_done,
  output logic [4:0]    xf_log2n,
  output logic [4:0]    xf_stage,
  output logic          xf_inv,
  output logic          xf_mul,
  output logic          xf_swap
);
  localparam int CW = $clog2(SLOTS+1);
  localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [CW-1:0] SLOTS_C = CW'(SLOTS);
  localparam logic [4:0]    MAXL_C  = 5'(MAX_LOG2);
  localparam logic [RW-1:0] RANK_C  = RW'(MY_RANK);
  localparam logic [AW-1:0] IADR_C  = AW'(INSTR_ADDR);
  localparam logic [AW-1:0] SADR_C  = AW'(STATUS_ADDR);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_END = 2'd2;
  localparam logic [1:0] PH_IDLE = 2'd0, PH_FETCH = 2'd1, PH_RUN = 2'd2;

  logic [31:0]   slot_q [SLOTS];
  logic [CW-1:0] cnt_q, ptr_q;
  logic [1:0]    st_q, ph_q;
  logic          err_q, inv_q, rm_q;
  logic [4:0]    len_q, stg_q;

  wire busy       = (st_q == ST_BUSY);
  wire ins_wr     = wr_en && (wr_addr == IADR_C);
  wire sts_wr     = wr_en && (wr_addr == SADR_C) && (wr_rank == RANK_C);
  wire [31:0] cur = slot_q[ptr_q[PW-1:0]];
  wire [4:0] cur_len = cur[6:2];
  wire cur_bad    = (cur[31:7] != '0) || (cur_len == 5'd0) || (cur_len > MAXL_C);
  wire last_instr = (ptr_q + CW'(1)) == cnt_q;
  wire last_stg   = (stg_q == len_q - 5'd1);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[i] <= '0;
      else if (ins_wr && !busy && cnt_q == CW'(i))
        slot_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      ptr_q <= '0;
      err_q <= 1'b0;
      len_q <= '0;
      stg_q <= '0;
      inv_q <= 1'b0;
      rm_q  <= 1'b0;
    end else if (!busy) begin
      if (ins_wr && cnt_q < SLOTS_C)
        cnt_q <= cnt_q + CW'(1);
      if (sts_wr && wr_data[1:0] == ST_IDLE) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
        err_q <= 1'b0;
      end else if (sts_wr && wr_data[1:0] == ST_BUSY) begin
        ptr_q <= '0;
        err_q <= 1'b0;
        if (cnt_q == '0) begin
          st_q <= ST_END;
        end else begin
          st_q <= ST_BUSY;
          ph_q <= PH_FETCH;
        end
      end
    end else begin
      case (ph_q)
        PH_FETCH: begin
          if (cur_bad) begin
            err_q <= 1'b1;
            ptr_q <= ptr_q + CW'(1);
            if (last_instr) begin
              st_q <= ST_END;
              ph_q <= PH_IDLE;
            end
          end else begin
            len_q <= cur_len;
            inv_q <= cur[0];
            rm_q  <= cur[1];
            stg_q <= '0;
            ph_q  <= PH_RUN;
          end
        end
        PH_RUN: begin
          if (stage_done) begin
            if (last_stg) begin
              ptr_q <= ptr_q + CW'(1);
              if (last_instr) begin
                st_q <= ST_END;
                ph_q <= PH_IDLE;
              end else begin
                ph_q <= PH_FETCH;
              end
            end else begin
              stg_q <= stg_q + 5'd1;
            end
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign stat_code   = st_q;
  assign stat_err    = err_q;
  assign instr_count = cnt_q;
  assign stage_req   = (ph_q == PH_RUN);
  assign xf_log2n    = len_q;
  assign xf_stage    = stg_q;
  assign xf_inv      = inv_q;
  assign xf_mul      = stage_req && rm_q && (inv_q ? (stg_q == 5'd0) : last_stg);
  assign xf_swap     = stage_req && inv_q && last_stg;

  a_r5_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stage_req |-> stat_code == ST_BUSY);
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    instr_count <= SLOTS_C);
  a_r10_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(instr_count));
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_req && !stage_done) |=> (stage_req && $stable(xf_stage)));
  a_r8_swap_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (xf_swap && stage_done) |=> (!stage_req || xf_stage == 5'd0));
endmodule

// File: tb/xform_sequencer_tb.sv
module xform_sequencer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, stage_done = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [0:0] wr_rank = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] stat_code, instr_count;
  logic stat_err, stage_req, xf_inv, xf_mul, xf_swap;
  logic [4:0] xf_log2n, xf_stage;
  int total = 0, bad = 0;
  logic [31:0] pw [3];
  int pn;

  always #10 clk = ~clk;

  xform_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_rank(wr_rank),
    .wr_data(wr_data), .stat_code(stat_code), .stat_err(stat_err),
    .instr_count(instr_count), .stage_req(stage_req), .stage_done(stage_done),
    .xf_log2n(xf_log2n), .xf_stage(xf_stage), .xf_inv(xf_inv), .xf_mul(xf_mul),
    .xf_swap(xf_swap));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit bad_word(logic [31:0] w);
    return (w[31:7] != 0) || (w[6:2] == 0) || (w[6:2] > 16);
  endfunction

  task automatic wr(logic [3:0] a, logic [0:0] r, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_rank = r; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(int n);
    wr(4'd1, 1'b0, 32'd0);
    for (int k = 0; k < n; k++) wr(4'd0, 1'(k), pw[k]);
  endtask

  task automatic run_prog();
    int mi = 0, ms = 0, guard = 0, hold = 0, dly = 0, L;
    bit fin = 0, anybad = 0, op, rm;
    for (int k = 0; k < pn; k++) if (bad_word(pw[k])) anybad = 1;
    while (mi < pn && bad_word(pw[mi])) mi++;
    while (!fin && guard < 3000) begin
      @(negedge clk);
      guard++;
      stage_done = 1'b0;
      if (stage_req) begin
        if (mi >= pn) begin
          chk("R6 extra stage", 1, 0);
          stage_done = 1'b1;
        end else if (hold < dly) begin
          hold++;
        end else begin
          L = int'(pw[mi][6:2]); op = pw[mi][0]; rm = pw[mi][1];
          chk("R2 log2n", xf_log2n, L);
          chk("R2 stage", xf_stage, ms);
          chk("R7 inv", xf_inv, op);
          chk("R7 mul", xf_mul, rm && (op ? ms == 0 : ms == L-1));
          chk("R8 swap", xf_swap, op && ms == L-1);
          stage_done = 1'b1; hold = 0; dly = (dly + 1) % 3; ms++;
          if (ms == L) begin
            ms = 0; mi++;
            while (mi < pn && bad_word(pw[mi])) mi++;
          end
        end
      end else if (stat_code == 2'd2) fin = 1;
    end
    stage_done = 1'b0;
    if (!fin) chk("R6 run timeout", 0, 1);
    chk("R6 end code", stat_code, 2);
    chk("R6 all run", mi, pn);
    chk("R9 err flag", stat_err, anybad);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 code", stat_code, 0); chk("R1 err", stat_err, 0);
    chk("R1 count", instr_count, 0); chk("R1 req", stage_req, 0);
    rst_n = 1'b1;

    for (int L = 0; L < 18; L++)
      for (int m = 0; m < 4; m++) begin
        pw[0] = {25'd0, 5'(L), 2'(m)}; pn = 1;
        load(1);
        chk("R3 count one", instr_count, 1);
        repeat (2) @(negedge clk);
        chk("R5 no start", stage_req, 0);
        wr(4'd1, 1'b0, 32'd1);
        chk("R5 busy code", stat_code, 1);
        run_prog();
      end

    pw[0] = 32'h80 | {25'd0, 5'd3, 2'd0}; pn = 1;
    load(1); wr(4'd1, 1'b0, 32'd1); run_prog();

    pw[0] = {25'd0, 5'd0, 2'd1}; pw[1] = {25'd0, 5'd3, 2'd3}; pn = 2;
    load(2); chk("R4 broadcast count", instr_count, 2);
    wr(4'd1, 1'b0, 32'd1); run_prog();

    pw[0] = {25'd0, 5'd2, 2'd2}; pw[1] = {25'd0, 5'd4, 2'd1}; pn = 2;
    load(2); wr(4'd1, 1'b0, 32'd1); run_prog();

    pw[0] = {25'd0, 5'd1, 2'd3}; pw[1] = {25'd0, 5'd1, 2'd2};
    pw[2] = {25'd0, 5'd5, 2'd0}; pn = 2;
    load(3); chk("R3 third dropped", instr_count, 2);
    wr(4'd1, 1'b0, 32'd1); run_prog();

    pw[0] = {25'd0, 5'd2, 2'd1}; pn = 1;
    load(1);
    wr(4'd1, 1'b1, 32'd1);
    repeat (3) @(negedge clk);
    chk("R4 foreign start code", stat_code, 0);
    chk("R4 foreign start req", stage_req, 0);
    wr(4'd1, 1'b0, 32'd1); run_prog();

    pw[0] = {25'd0, 5'd16, 2'd0}; pn = 1;
    load(1); wr(4'd1, 1'b0, 32'd1);
    repeat (2) @(negedge clk);
    wr(4'd0, 1'b0, {25'd0, 5'd2, 2'd1});
    wr(4'd1, 1'b0, 32'd0);
    chk("R10 count frozen", instr_count, 1);
    chk("R10 still busy", stat_code, 1);
    run_prog();

    pw[0] = {25'd0, 5'd0, 2'd0}; pn = 1;
    load(1); wr(4'd1, 1'b0, 32'd1); run_prog();
    wr(4'd1, 1'b0, 32'd0);
    chk("R11 code", stat_code, 0); chk("R11 err", stat_err, 0);
    chk("R11 count", instr_count, 0);

    wr(4'd1, 1'b0, 32'd1);
    chk("R12 empty end", stat_code, 2);
    repeat (2) @(negedge clk);
    chk("R12 no req", stage_req, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule